// File: doc/BRIEF.md
# GPIO Controller with Edge-Triggered Event Capture

A 32-pin general-purpose I/O block controlled through a small memory-mapped register port: a byte address, a write strobe, write data and a combinational read data bus. Each pin can be an input or an output. An output drives either push-pull or open-drain. Inputs pass through a two-flop synchronizer. A per-pin edge detector then records the selected transitions in a sticky event register. Software clears that register by writing ones to it. A single interrupt line is the OR of every event that is enabled in the mask register.

Register bits use big-endian numbering: pin n sits at register bit 31-n, so pin 0 is the MSB. The pin ports of the block use ordinary indexing, where port bit n is pin n. The parameter `EXT_MODE` chooses one of two variants:
- **Basic mode:** one sense bit per pin.
- **Extended mode:** a two-bit sense code per pin, split across two sense registers, and the last four pins are input only.

Register word offsets: 0x00 direction, 0x04 open-drain, 0x08 data, 0x0C events, 0x10 mask, 0x14 sense A, 0x18 sense B. Offsets 0x1C and up read as zero, and writes to them are ignored.

Top module: `gpio_event_ctrl`

## Requirements
- R1: Pin n (0..31) is controlled and reported by bit 31-n of every register.
- R2: A direction bit of 1 makes the pin an output. A push-pull output pin drives `pin_o` equal to its data bit with `pin_oe_o` high. An input pin has `pin_oe_o` low.
- R3: When a pin is an output and its open-drain bit is 1, data 0 gives `pin_oe_o`=1 with `pin_o`=0, and data 1 gives `pin_oe_o`=0.
- R4: Reading the data register returns the written latch for output pins and the synchronized level for input pins. A pin change is seen in the data read after two clock edges and in the event register after three.
- R5: Writing to the event register clears every bit written as 1 and leaves every bit written as 0 unchanged. Writing all ones clears all events.
- R6: When an edge is detected in the same cycle as a clearing write to that bit, the event stays set.
- R7: `irq_o` is high exactly when the AND of the event and mask registers is nonzero. A mask bit of 1 enables the pin.
- R8: In basic mode, a sense A bit of 1 records only high-to-low transitions, and 0 records both edges. Offset 0x18 reads zero and ignores writes.
- R9: In extended mode, pin n uses a two-bit field in sense A (pins 0..15) or sense B (pins 16..31) at bit offset (15 - n mod 16)*2. Code 0 records both edges, 1 rising, 2 falling, and 3 records nothing.
- R10: In extended mode, pins 28..31 are input only. Their direction bits (register bits 3..0) always read 0 and never enable the output.
- R11: After reset, every register is zero, every pin is an input, no event is pending and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 5 | Byte address of the register |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| pin_i | input | 32 | Pin levels, bit n = pin n |
| pin_o | output | 32 | Output values, bit n = pin n |
| pin_oe_o | output | 32 | Output enables, bit n = pin n |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench targets the following corner cases, and each one exposes a specific class of bug:
- **Bit reversal.** A design that maps pin n to bit n enables the wrong pad.
- **Synchronizer latency.** Skipping the synchronizer, or adding an extra stage, shifts when the event appears by a cycle.
- **Edge arriving with a clear.** If the clear wins, the edge is silently lost.
- **Reserved sense code 3.** Decoding it as "both edges" records spurious events.
- **Misplaced sense fields.** Wrong field offsets give a pin the sense of its neighbour.
- **Input-only pins.** If their direction bits are not forced, those pads can be driven.

A behavioural model of both parameter variants runs beside the two instances and compares read data, pins and interrupt on every clock under random traffic.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned SEL_W  = ADDR_W - 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_DIR  = 3'd0,
    SEL_ODR  = 3'd1,
    SEL_DAT  = 3'd2,
    SEL_EVT  = 3'd3,
    SEL_MSK  = 3'd4,
    SEL_SNSA = 3'd5,
    SEL_SNSB = 3'd6,
    SEL_NONE = 3'd7
  } reg_sel_e;

  localparam logic [1:0] SNS_BOTH = 2'd0;
  localparam logic [1:0] SNS_RISE = 2'd1;
  localparam logic [1:0] SNS_FALL = 2'd2;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign prev_o = s3_q;
endmodule

// File: rtl/gpio_edge_sense.sv
module gpio_edge_sense import gpio_evt_pkg::*; #(
  parameter int unsigned NPINS = 32,
  parameter bit          EXT   = 1'b0
) (
  input  logic [NPINS-1:0] lvl_i,
  input  logic [NPINS-1:0] prev_i,
  input  logic [NPINS-1:0] snsa_i,
  input  logic [NPINS-1:0] snsb_i,
  output logic [NPINS-1:0] hit_o
);
  localparam int unsigned HALF = NPINS / 2;

  logic [NPINS-1:0] rise, fall;
  assign rise = lvl_i & ~prev_i;
  assign fall = ~lvl_i & prev_i;

  if (EXT) begin : g_ext
    for (genvar b = 0; b < NPINS; b++) begin : g_bit
      localparam int unsigned PIN = NPINS - 1 - b;
      localparam int unsigned OFS = (HALF - 1 - (PIN % HALF)) * 2;
      logic [1:0] code;
      if (PIN < HALF) begin : g_a
        assign code = snsa_i[OFS +: 2];
      end else begin : g_b
        assign code = snsb_i[OFS +: 2];
      end
      always_comb begin
        unique case (code)
          SNS_BOTH: hit_o[b] = rise[b] | fall[b];
          SNS_RISE: hit_o[b] = rise[b];
          SNS_FALL: hit_o[b] = fall[b];
          default:  hit_o[b] = 1'b0; // reserved code
        endcase
      end
    end
  end else begin : g_basic
    logic unused_snsb;
    assign unused_snsb = ^snsb_i;
    assign hit_o = fall | (rise & ~snsa_i);
  end
endmodule

// File: rtl/gpio_evt_latch.sv
module gpio_evt_latch #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] hit_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] ev_o
);
  logic [W-1:0] ev_q;

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ev_q <= '0;
    else         ev_q <= (ev_q & ~clr_i) | hit_i;
  end

  assign ev_o = ev_q;

  AST_EVT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(ev_q) & ~$past(clr_i) & ~ev_q) == '0)); // R5

  AST_HIT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(hit_i) & ~ev_q) == '0)); // R6
endmodule

// File: rtl/gpio_event_ctrl.sv
module gpio_event_ctrl import gpio_evt_pkg::*; #(
  parameter int unsigned NPINS   = 32,
  parameter bit          EXT_MODE = 1'b0,
  parameter int unsigned IN_ONLY = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [NPINS-1:0]  wdata_i,
  output logic [NPINS-1:0]  rdata_o,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pin_o,
  output logic [NPINS-1:0]  pin_oe_o,
  output logic              irq_o
);
  reg_sel_e sel;
  logic unused_addr;
  assign sel = reg_sel_e'(addr_i[ADDR_W-1:2]);
  assign unused_addr = ^addr_i[1:0];

  logic [NPINS-1:0] dir_q, odr_q, dat_q, msk_q, snsa_q, snsb_q;
  logic [NPINS-1:0] dir_wmask, pin_reg, lvl, prev, hit, clr, evt;

  // pin n <-> register bit NPINS-1-n
  for (genvar b = 0; b < NPINS; b++) begin : g_map
    localparam int unsigned PIN = NPINS - 1 - b;
    assign dir_wmask[b] = !(EXT_MODE && (b < IN_ONLY));
    assign pin_reg[b]   = pin_i[PIN];
    assign pin_o[PIN]    = dat_q[b] & ~odr_q[b];
    assign pin_oe_o[PIN] = dir_q[b] & (~odr_q[b] | ~dat_q[b]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      odr_q  <= '0;
      dat_q  <= '0;
      msk_q  <= '0;
      snsa_q <= '0;
    end else if (we_i) begin
      unique case (sel)
        SEL_DIR:  dir_q  <= wdata_i & dir_wmask;
        SEL_ODR:  odr_q  <= wdata_i;
        SEL_DAT:  dat_q  <= wdata_i;
        SEL_MSK:  msk_q  <= wdata_i;
        SEL_SNSA: snsa_q <= wdata_i;
        default: ;
      endcase
    end
  end

  if (EXT_MODE) begin : g_snsb
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         snsb_q <= '0;
      else if (we_i && (sel == SEL_SNSB))  snsb_q <= wdata_i;
    end
  end else begin : g_no_snsb
    assign snsb_q = '0;
  end

  assign clr = (we_i && (sel == SEL_EVT)) ? wdata_i : '0;

  gpio_in_sync #(.W(NPINS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_reg),
    .lvl_o (lvl),
    .prev_o(prev)
  );

  gpio_edge_sense #(.NPINS(NPINS), .EXT(EXT_MODE)) u_sense (
    .lvl_i (lvl),
    .prev_i(prev),
    .snsa_i(snsa_q),
    .snsb_i(snsb_q),
    .hit_o (hit)
  );

  gpio_evt_latch #(.W(NPINS)) u_evt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hit_i (hit),
    .clr_i (clr),
    .ev_o  (evt)
  );

  always_comb begin
    unique case (sel)
      SEL_DIR:  rdata_o = dir_q;
      SEL_ODR:  rdata_o = odr_q;
      SEL_DAT:  rdata_o = (dat_q & dir_q) | (lvl & ~dir_q);
      SEL_EVT:  rdata_o = evt;
      SEL_MSK:  rdata_o = msk_q;
      SEL_SNSA: rdata_o = snsa_q;
      SEL_SNSB: rdata_o = snsb_q;
      default:  rdata_o = '0;
    endcase
  end

  assign irq_o = |(evt & msk_q);

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (msk_q != '0)); // R7

  AST_INPUT_ONLY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    EXT_MODE |-> (pin_oe_o[NPINS-1 -: IN_ONLY] == '0)); // R10

  AST_DAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && (sel == SEL_DAT)) |=> $stable(dat_q)); // R4
endmodule

// File: tb/gpio_event_ctrl_test.sv
`timescale 1ns/1ps
module gpio_event_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] pins = '0;
  logic [31:0] rd_b, rd_x, po_b, po_x, oe_b, oe_x;
  logic        irq_b, irq_x;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_event_ctrl #(.EXT_MODE(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rd_b), .pin_i(pins), .pin_o(po_b), .pin_oe_o(oe_b), .irq_o(irq_b));

  gpio_event_ctrl #(.EXT_MODE(1'b1)) uut_x (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rd_x), .pin_i(pins), .pin_o(po_x), .pin_oe_o(oe_x), .irq_o(irq_x));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model, index 0 basic, 1 extended
  logic [31:0] m_dir[2], m_odr[2], m_dat[2], m_ev[2], m_msk[2];
  logic [31:0] m_sa[2], m_sb[2], m_y1[2], m_y2[2], m_y3[2];

  function automatic logic [31:0] rev(logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  function automatic logic hitf(int m, int b);
    int n = 31 - b;
    logic r = m_y2[m][b] & ~m_y3[m][b];
    logic f = ~m_y2[m][b] & m_y3[m][b];
    logic [1:0] c;
    if (m == 0) return f | (r & ~m_sa[m][b]);
    c = (n < 16) ? m_sa[m][(15-n)*2 +: 2] : m_sb[m][(15-(n-16))*2 +: 2];
    case (c)
      2'd0: return r | f;
      2'd1: return r;
      2'd2: return f;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(int m, logic [4:0] a);
    case (a[4:2])
      3'd0: return m_dir[m];
      3'd1: return m_odr[m];
      3'd2: return (m_dat[m] & m_dir[m]) | (m_y2[m] & ~m_dir[m]);
      3'd3: return m_ev[m];
      3'd4: return m_msk[m];
      3'd5: return m_sa[m];
      3'd6: return (m == 1) ? m_sb[m] : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag(logic [4:0] a);
    case (a[4:2])
      3'd0: return "R2 dir read";
      3'd1: return "R3 odr read";
      3'd2: return "R4 data read";
      3'd3: return "R5 event read";
      3'd4: return "R7 mask read";
      3'd5: return "R8 sense A read";
      3'd6: return "R9 sense B read";
      default: return "R1 unmapped read";
    endcase
  endfunction

  always @(posedge clk) begin
    for (int m = 0; m < 2; m++) begin
      if (!rst_n) begin
        m_dir[m] = '0; m_odr[m] = '0; m_dat[m] = '0; m_ev[m] = '0; m_msk[m] = '0;
        m_sa[m] = '0; m_sb[m] = '0; m_y1[m] = '0; m_y2[m] = '0; m_y3[m] = '0;
      end else begin
        logic [31:0] h;
        for (int b = 0; b < 32; b++) h[b] = hitf(m, b);
        if (we) begin
          case (addr[4:2])
            3'd0: m_dir[m] = (m == 1) ? (wdata & 32'hFFFF_FFF0) : wdata;
            3'd1: m_odr[m] = wdata;
            3'd2: m_dat[m] = wdata;
            3'd3: m_ev[m] = m_ev[m] & ~wdata;
            3'd4: m_msk[m] = wdata;
            3'd5: m_sa[m] = wdata;
            3'd6: if (m == 1) m_sb[m] = wdata;
            default: ;
          endcase
        end
        m_ev[m] = m_ev[m] | h;
        m_y3[m] = m_y2[m];
        m_y2[m] = m_y1[m];
        m_y1[m] = rev(pins);
      end
    end
    #1;
    for (int m = 0; m < 2; m++) begin
      logic [31:0] eo, eoe;
      for (int n = 0; n < 32; n++) begin
        eo[n]  = m_dat[m][31-n] & ~m_odr[m][31-n];
        eoe[n] = m_dir[m][31-n] & (~m_odr[m][31-n] | ~m_dat[m][31-n]);
      end
      chk(rd_tag(addr), m ? rd_x : rd_b, exp_rd(m, addr));
      chk("R2 pin_o", m ? po_x : po_b, eo);
      chk("R3 pin_oe_o", m ? oe_x : oe_b, eoe);
      chk("R7 irq", {31'b0, m ? irq_x : irq_b}, {31'b0, |(m_ev[m] & m_msk[m])});
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rdc(int m, logic [4:0] a, logic [31:0] exp, string tag);
    addr = a;
    #1;
    chk(tag, m ? rd_x : rd_b, exp);
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    wait_n(4);
    for (int a = 0; a < 8; a++) rdc(0, 5'(a * 4), 32'h0, "R11 reset value");
    chk("R11 reset oe", oe_b, 32'h0);
    chk("R11 reset irq", {31'b0, irq_b}, 32'h0);
    rst_n = 1'b1;
    wait_n(2);

    // R1/R2: pin 0 is the MSB
    wr(5'h00, 32'h8000_0000);
    wr(5'h08, 32'h8000_0000);
    #1;
    chk("R1 pin0 oe from bit31", oe_b, 32'h0000_0001);
    chk("R2 push-pull drives data", po_b & 32'h1, 32'h1);
    // R3 open drain
    wr(5'h04, 32'h8000_0000);
    #1;
    chk("R3 open-drain released on 1", oe_b, 32'h0);
    wr(5'h08, 32'h0);
    #1;
    chk("R3 open-drain drives low oe", oe_b, 32'h1);
    chk("R3 open-drain drives low value", po_b & 32'h1, 32'h0);

    // R4 latency on pin 5 (bit 26)
    pins[5] = 1'b1;
    wait_n(2);
    rdc(0, 5'h0C, 32'h0, "R4 no event after two edges");
    rdc(0, 5'h08, 32'h0400_0000, "R4 data shows input level");
    wait_n(1);
    rdc(0, 5'h0C, 32'h0400_0000, "R4 event after three edges");

    // R5 write-one-to-clear
    wr(5'h0C, 32'h0);
    rdc(0, 5'h0C, 32'h0400_0000, "R5 zero write keeps event");
    wr(5'h0C, 32'h0400_0000);
    rdc(0, 5'h0C, 32'h0, "R5 one write clears event");

    // R8 falling only
    wr(5'h14, 32'h0400_0000);
    pins[5] = 1'b0;
    wait_n(4);
    rdc(0, 5'h0C, 32'h0400_0000, "R8 falling recorded");
    wr(5'h0C, 32'hFFFF_FFFF);
    pins[5] = 1'b1;
    wait_n(4);
    rdc(0, 5'h0C, 32'h0, "R8 rising ignored when falling-only");

    // R6 edge collides with clear
    wr(5'h14, 32'h0);
    pins[5] = 1'b0;
    wait_n(2);
    wr(5'h0C, 32'h0400_0000);
    rdc(0, 5'h0C, 32'h0400_0000, "R6 edge beats clear");

    // R7 mask
    wr(5'h10, 32'h0400_0000);
    #1;
    chk("R7 irq when enabled", {31'b0, irq_b}, 32'h1);
    wr(5'h10, 32'h0);
    #1;
    chk("R7 irq masked", {31'b0, irq_b}, 32'h0);

    // R9 extended sense fields
    wr(5'h14, 32'h1 << 26);
    wr(5'h18, 32'h3 << 22);
    rdc(0, 5'h18, 32'h0, "R8 basic sense B reads zero");
    rdc(1, 5'h18, 32'h3 << 22, "R9 ext sense B stored");
    wr(5'h0C, 32'hFFFF_FFFF);
    pins[2] = 1'b1;
    wait_n(4);
    rdc(1, 5'h0C, 32'h2000_0000, "R9 pin2 rise code 1");
    wr(5'h0C, 32'hFFFF_FFFF);
    pins[2] = 1'b0;
    wait_n(4);
    rdc(1, 5'h0C, 32'h0, "R9 pin2 fall ignored code 1");
    pins[20] = 1'b1;
    wait_n(4);
    pins[20] = 1'b0;
    wait_n(4);
    rdc(1, 5'h0C, 32'h0, "R9 reserved code 3 records none");

    // R10 input-only pins
    wr(5'h04, 32'h0);
    wr(5'h08, 32'hFFFF_FFFF);
    wr(5'h00, 32'hFFFF_FFFF);
    rdc(1, 5'h00, 32'hFFFF_FFF0, "R10 ext dir bits 3..0 read 0");
    chk("R10 pins 28..31 not driven", oe_x & 32'hF000_0000, 32'h0);
    chk("R10 basic drives all", oe_b, 32'hFFFF_FFFF);

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if ($urandom % 6 == 0) pins[$urandom % 32] ^= 1'b1;
      addr  = 5'(($urandom % 8) * 4);
      wdata = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
      we    = ($urandom % 4 == 0);
    end
    @(negedge clk);
    we = 1'b0;
    wait_n(2);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule